// File: doc/BRIEF.md
# Event Timer Register File and Main Counter

This block is the software-visible front of a multi-timer event unit. It holds a read-only capability word, a global control register, an interrupt status register, a free-running 64-bit main counter and, for each timer, a configuration, a comparator and a route register. Software reaches all of them through one register port that takes 4-byte or 8-byte accesses. Address bit 2 picks the upper half of a register.

The main counter advances by one on every cycle that `tick_i` is high while the global enable is set. When the enable is clear it holds its value and can still be written. A counter write made while counting is still accepted, and it raises a one-cycle warning. Comparator matching and interrupt delivery belong to neighbouring blocks. This block exports the counter, the enables, the status bits and every timer's configuration and comparator for those blocks to use. The neighbours report timer events back through `irq_set_i`.

Top module: `evtr_regfile`

## Requirements
- R1: After reset the counter, the global control register and the status register read zero. Each timer's configuration reads `{ROUTE_CAP, 32'h30}`, and each comparator reads all ones.
- R2: The capability register at offset 0x000 reads `{PERIOD_FS, 16'h0, 1, 0, 1, N_TIMERS-1 (5 bits), 8'h01}`. This puts the timer count minus one in bits [12:8], the 64-bit-counter flag in bit 13, the legacy-route flag in bit 15 and the tick period in femtoseconds in bits [63:32]. Writes to it are ignored.
- R3: An 8-byte access with address bit 2 clear moves the whole register. Any other access moves only the 32-bit half chosen by address bit 2. Read data for such an access is right-justified and zero-extended.
- R4: While global control bit 0 (enable) is set, the counter at 0x0F0 rises by exactly one per cycle with `tick_i` high. While the enable is clear, it holds.
- R5: The counter can be written in either state, and the write takes priority over a tick in the same cycle. A write while the enable is set drives `cnt_warn_o` high in the following cycle.
- R6: Global control at 0x010 keeps only bit 0 (enable, also `run_o`) and bit 1 (legacy route, also `legacy_o`). All other bits read zero.
- R7: In a timer configuration write, only bits 1, 2, 3, 8 and 13:9 change. Bits 4 and 5 stay 1 and bits [63:32] stay `ROUTE_CAP`.
- R8: Timer i occupies 0x100 + 0x20*i. Address bits [4:3] select the register: 0 configuration, 1 comparator, 2 route. Value 3 reads zero.
- R9: A timer window address whose index is N_TIMERS or more reads zero, and writes to it change no register.
- R10: When configuration bit 8 (32-bit mode) is set, the comparator's upper word is forced to zero. In that mode, lower-half and 8-byte comparator writes load only the low word, and upper-half writes are ignored.
- R11: Status bit i is set by a pulse on `irq_set_i[i]` and cleared by writing 1 to that bit at 0x020. If a set and a clear arrive in the same cycle, the set wins.
- R12: `rvalid_o` goes high exactly one cycle after a read request, and `rdata_o` then holds the register value as it was in the request cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Counter advance strobe |
| req_i | input | 1 | Register access request |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 10 | Byte address |
| req_size64_i | input | 1 | 1 = 8-byte access, 0 = 4-byte |
| req_wdata_i | input | 64 | Write data (32-bit writes use bits [31:0]) |
| irq_set_i | input | N_TIMERS | Timer event pulses that set status bits |
| rvalid_o | output | 1 | Read data valid |
| rdata_o | output | 64 | Read data |
| run_o | output | 1 | Global enable |
| legacy_o | output | 1 | Legacy route select |
| counter_o | output | 64 | Main counter |
| cnt_warn_o | output | 1 | Counter written while running |
| stat_o | output | N_TIMERS | Interrupt status bits |
| tmr_cfg_o | output | 64*N_TIMERS | Timer configurations, timer i at [64i+63:64i] |
| tmr_cmp_o | output | 64*N_TIMERS | Timer comparators, timer i at [64i+63:64i] |

## Verification
Some properties can be checked on every cycle, and the assertions cover those. They include counter stepping and holding, the warning being tied to a write while running, read-valid timing, status set on an event, the fixed capability bits in timer configuration, and the zero upper comparator word in 32-bit mode. Other behaviour needs a chosen sequence of accesses, so only the bench scenarios show it. That covers the address decode across the timer window, out-of-range and reserved slots, half-word merging, write-1-to-clear with set priority, and the exact counter value after a write that races a tick and a disable.

// File: rtl/evtr_pkg.sv
package evtr_pkg;

    localparam int AW = 10;

    localparam logic [AW-1:0] A_CAP   = 10'h000;
    localparam logic [AW-1:0] A_GCFG  = 10'h010;
    localparam logic [AW-1:0] A_STAT  = 10'h020;
    localparam logic [AW-1:0] A_CNT   = 10'h0F0;
    localparam logic [AW-1:0] A_TBASE = 10'h100;

    localparam logic [63:0] GCFG_WMASK = 64'h3;
    localparam logic [63:0] TCFG_WMASK = 64'h3F0E;
    localparam logic [31:0] TCFG_FIXED = 32'h30;
    localparam int          TC_M32     = 8;

    typedef enum logic [1:0] {
        TSEL_CFG   = 2'd0,
        TSEL_CMP   = 2'd1,
        TSEL_ROUTE = 2'd2,
        TSEL_RSVD  = 2'd3
    } tsel_e;

    typedef struct packed {
        logic        size64;
        logic        hi;
        logic [63:0] data;
    } lane_t;

    // Replace the half (or whole) of a register picked by an access.
    function automatic logic [63:0] lane_merge(logic [63:0] old, lane_t l);
        if (l.size64 && !l.hi) return l.data;
        else if (l.hi)         return {l.data[31:0], old[31:0]};
        else                   return {old[63:32], l.data[31:0]};
    endfunction

    function automatic logic [63:0] lane_read(logic [63:0] v, logic size64, logic hi);
        if (size64 && !hi) return v;
        else if (hi)       return {32'h0, v[63:32]};
        else               return {32'h0, v[31:0]};
    endfunction

    function automatic logic [63:0] apply_mask(logic [63:0] old, logic [63:0] nv,
                                               logic [63:0] mask);
        return (nv & mask) | (old & ~mask);
    endfunction

endpackage

// File: rtl/evtr_counter.sv
module evtr_counter
    import evtr_pkg::*;
(
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic        run_i,
    input  logic        tick_i,
    input  logic        wr_i,
    input  lane_t       lane_i,
    output logic [63:0] count_o,
    output logic        warn_o
);

    typedef struct packed {
        logic [63:0] count;
        logic        warn;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.warn = wr_i && run_i;
        if (wr_i)
            st_d.count = lane_merge(st_q.count, lane_i);
        else if (run_i && tick_i)
            st_d.count = st_q.count + 64'd1;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign count_o = st_q.count;
    assign warn_o  = st_q.warn;

endmodule

// File: rtl/evtr_timer_slot.sv
module evtr_timer_slot
    import evtr_pkg::*;
#(
    parameter logic [31:0] ROUTE_CAP = 32'h0000_0F00
) (
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic        wr_i,
    input  tsel_e       sel_i,
    input  lane_t       lane_i,
    output logic [63:0] cfg_o,
    output logic [63:0] cmp_o,
    output logic [63:0] route_o
);

    localparam logic [63:0] CFG_RST = {ROUTE_CAP, TCFG_FIXED};

    typedef struct packed {
        logic [63:0] cfg;
        logic [63:0] cmp;
        logic [63:0] route;
    } slot_st_t;

    slot_st_t    st_d, st_q;
    logic [63:0] cfg_merged;

    always_comb begin
        st_d       = st_q;
        cfg_merged = lane_merge(st_q.cfg, lane_i);
        if (wr_i) begin
            case (sel_i)
                TSEL_CFG: begin
                    st_d.cfg = apply_mask(st_q.cfg, cfg_merged, TCFG_WMASK);
                    if (st_d.cfg[TC_M32])
                        st_d.cmp = {32'h0, st_q.cmp[31:0]};
                end
                TSEL_CMP: begin
                    if (st_q.cfg[TC_M32]) begin
                        if (!lane_i.hi)
                            st_d.cmp = {32'h0, lane_i.data[31:0]};
                    end else begin
                        st_d.cmp = lane_merge(st_q.cmp, lane_i);
                    end
                end
                TSEL_ROUTE: st_d.route = lane_merge(st_q.route, lane_i);
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q.cfg   <= CFG_RST;
            st_q.cmp   <= '1;
            st_q.route <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg_o   = st_q.cfg;
    assign cmp_o   = st_q.cmp;
    assign route_o = st_q.route;

endmodule

// File: rtl/evtr_regfile.sv
module evtr_regfile
    import evtr_pkg::*;
#(
    parameter int          N_TIMERS  = 3,
    parameter logic [31:0] PERIOD_FS = 32'd10_000_000,
    parameter logic [31:0] ROUTE_CAP = 32'h0000_0F00
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  tick_i,
    input  logic                  req_i,
    input  logic                  req_we_i,
    input  logic [9:0]            req_addr_i,
    input  logic                  req_size64_i,
    input  logic [63:0]           req_wdata_i,
    input  logic [N_TIMERS-1:0]   irq_set_i,
    output logic                  rvalid_o,
    output logic [63:0]           rdata_o,
    output logic                  run_o,
    output logic                  legacy_o,
    output logic [63:0]           counter_o,
    output logic                  cnt_warn_o,
    output logic [N_TIMERS-1:0]   stat_o,
    output logic [N_TIMERS*64-1:0] tmr_cfg_o,
    output logic [N_TIMERS*64-1:0] tmr_cmp_o
);

    localparam int TIDX_W = 5;
    localparam logic [63:0] CAP_VAL =
        {PERIOD_FS, 16'h0, 1'b1, 1'b0, 1'b1, 5'(N_TIMERS - 1), 8'h01};

    typedef struct packed {
        logic [1:0]          gcfg;
        logic [N_TIMERS-1:0] stat;
        logic                rvalid;
        logic [63:0]         rdata;
    } top_st_t;

    top_st_t st_d, st_q;

    // Access decode
    lane_t             lane;
    logic              in_win, t_hit, wr_acc;
    logic [TIDX_W-1:0] tidx;
    logic [AW-1:0]     reg_ofs;
    tsel_e             tsel;

    assign lane    = '{size64: req_size64_i, hi: req_addr_i[2], data: req_wdata_i};
    assign in_win  = req_addr_i >= A_TBASE;
    assign tidx    = TIDX_W'((req_addr_i - A_TBASE) >> 5);
    assign t_hit   = in_win && (32'(tidx) < N_TIMERS);
    assign tsel    = tsel_e'(req_addr_i[4:3]);
    assign reg_ofs = {req_addr_i[AW-1:3], 3'b000};
    assign wr_acc  = req_i && req_we_i;

    // Timer slots
    logic [63:0] cfg_a   [N_TIMERS];
    logic [63:0] cmp_a   [N_TIMERS];
    logic [63:0] route_a [N_TIMERS];

    for (genvar gi = 0; gi < N_TIMERS; gi++) begin : g_slot
        evtr_timer_slot #(.ROUTE_CAP(ROUTE_CAP)) u_slot (
            .clk_i   (clk_i),
            .rst_ni  (rst_ni),
            .wr_i    (wr_acc && t_hit && (tidx == TIDX_W'(gi))),
            .sel_i   (tsel),
            .lane_i  (lane),
            .cfg_o   (cfg_a[gi]),
            .cmp_o   (cmp_a[gi]),
            .route_o (route_a[gi])
        );
        assign tmr_cfg_o[gi*64 +: 64] = cfg_a[gi];
        assign tmr_cmp_o[gi*64 +: 64] = cmp_a[gi];
    end

    // Main counter
    logic [63:0] count;
    evtr_counter u_cnt (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .run_i   (st_q.gcfg[0]),
        .tick_i  (tick_i),
        .wr_i    (wr_acc && !in_win && (reg_ofs == A_CNT)),
        .lane_i  (lane),
        .count_o (count),
        .warn_o  (cnt_warn_o)
    );

    // Global registers and read path
    logic [63:0]         raw;
    logic [63:0]         gcfg_new;
    logic [N_TIMERS-1:0] clr;

    always_comb begin
        st_d = st_q;

        raw = '0;
        if (in_win) begin
            for (int i = 0; i < N_TIMERS; i++) begin
                if (tidx == TIDX_W'(i)) begin
                    case (tsel)
                        TSEL_CFG:   raw = cfg_a[i];
                        TSEL_CMP:   raw = cmp_a[i];
                        TSEL_ROUTE: raw = route_a[i];
                        default:    raw = '0;
                    endcase
                end
            end
        end else begin
            case (reg_ofs)
                A_CAP:   raw = CAP_VAL;
                A_GCFG:  raw = {62'h0, st_q.gcfg};
                A_STAT:  raw = 64'(st_q.stat);
                A_CNT:   raw = count;
                default: raw = '0;
            endcase
        end

        st_d.rvalid = req_i && !req_we_i;
        if (st_d.rvalid)
            st_d.rdata = lane_read(raw, lane.size64, lane.hi);

        gcfg_new = apply_mask({62'h0, st_q.gcfg},
                              lane_merge({62'h0, st_q.gcfg}, lane), GCFG_WMASK);
        if (wr_acc && !in_win && (reg_ofs == A_GCFG))
            st_d.gcfg = gcfg_new[1:0];

        clr = '0;
        if (wr_acc && !in_win && (reg_ofs == A_STAT) && !lane.hi)
            clr = req_wdata_i[N_TIMERS-1:0];
        st_d.stat = (st_q.stat & ~clr) | irq_set_i;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign rvalid_o  = st_q.rvalid;
    assign rdata_o   = st_q.rdata;
    assign run_o     = st_q.gcfg[0];
    assign legacy_o  = st_q.gcfg[1];
    assign counter_o = count;
    assign stat_o    = st_q.stat;

endmodule

// File: rtl/evtr_regfile_chk.sv
module evtr_regfile_chk
    import evtr_pkg::*;
#(
    parameter logic [31:0] ROUTE_CAP = 32'h0000_0F00
) (
    input logic        clk_i,
    input logic        rst_ni,
    input logic        tick_i,
    input logic        req_i,
    input logic        req_we_i,
    input logic [9:0]  req_addr_i,
    input logic        rvalid_o,
    input logic        run_o,
    input logic [63:0] counter_o,
    input logic        cnt_warn_o,
    input logic        irq0_i,
    input logic        stat0_i,
    input logic [63:0] t0_cfg_i,
    input logic [63:0] t0_cmp_i
);

    logic cnt_wr;
    assign cnt_wr = req_i && req_we_i && (req_addr_i[9:3] == A_CNT[9:3]);

    // R4: counter steps by one when running and ticked
    p_cnt_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (run_o && tick_i && !cnt_wr) |=> (counter_o == $past(counter_o) + 64'd1));

    // R4: counter holds while halted
    p_cnt_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!run_o && !cnt_wr) |=> $stable(counter_o));

    // R5: warning only after a counter write while running
    p_warn_cause_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (run_o && cnt_wr) |=> cnt_warn_o);

    p_warn_only_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(run_o && cnt_wr) |=> !cnt_warn_o);

    // R12: read valid one cycle after a read request
    p_rvalid_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_i && !req_we_i) |=> rvalid_o);

    p_no_rvalid_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(req_i && !req_we_i) |=> !rvalid_o);

    // R11: event sets status
    p_stat_set_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq0_i |=> stat0_i);

    // R7: capability bits of timer configuration stay fixed
    p_tcfg_caps_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (t0_cfg_i[63:32] == ROUTE_CAP) && (t0_cfg_i[5:4] == 2'b11));

    // R10: 32-bit mode keeps the comparator upper word zero
    p_m32_cmp_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        t0_cfg_i[TC_M32] |-> (t0_cmp_i[63:32] == 32'h0));

endmodule

bind evtr_regfile evtr_regfile_chk #(.ROUTE_CAP(ROUTE_CAP)) u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_i),
    .req_i      (req_i),
    .req_we_i   (req_we_i),
    .req_addr_i (req_addr_i),
    .rvalid_o   (rvalid_o),
    .run_o      (run_o),
    .counter_o  (counter_o),
    .cnt_warn_o (cnt_warn_o),
    .irq0_i     (irq_set_i[0]),
    .stat0_i    (stat_o[0]),
    .t0_cfg_i   (tmr_cfg_o[63:0]),
    .t0_cmp_i   (tmr_cmp_o[63:0])
);

// File: tb/tb_evtr_regfile.sv
module tb_evtr_regfile;

    localparam int          CLK_PERIOD = 10;
    localparam int          NT         = 3;
    localparam logic [31:0] PFS        = 32'd10_000_000;
    localparam logic [31:0] RCAP       = 32'h0000_0F00;
    localparam logic [63:0] TCFG_RST   = {RCAP, 32'h30};

    logic              clk = 0;
    logic              rst_n = 0;
    logic              tick = 0;
    logic              req = 0;
    logic              we = 0;
    logic [9:0]        addr = '0;
    logic              sz64 = 0;
    logic [63:0]       wdata = '0;
    logic [NT-1:0]     irq = '0;
    logic              rvalid;
    logic [63:0]       rdata;
    logic              run, legacy, warn;
    logic [63:0]       counter;
    logic [NT-1:0]     stat;
    logic [NT*64-1:0]  tcfg, tcmp;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;
    logic last_rv;
    logic last_warn;

    always #(CLK_PERIOD/2) clk = ~clk;

    evtr_regfile #(.N_TIMERS(NT), .PERIOD_FS(PFS), .ROUTE_CAP(RCAP)) dut (
        .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .req_i(req), .req_we_i(we),
        .req_addr_i(addr), .req_size64_i(sz64), .req_wdata_i(wdata),
        .irq_set_i(irq), .rvalid_o(rvalid), .rdata_o(rdata), .run_o(run),
        .legacy_o(legacy), .counter_o(counter), .cnt_warn_o(warn),
        .stat_o(stat), .tmr_cfg_o(tcfg), .tmr_cmp_o(tcmp)
    );

    task automatic check(string tag, logic [63:0] got, logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic bus_wr(logic [9:0] a, logic [63:0] d, logic s64);
        @(negedge clk);
        req = 1; we = 1; addr = a; wdata = d; sz64 = s64;
        @(negedge clk);
        req = 0; we = 0;
        last_warn = warn;
    endtask

    task automatic bus_rd(logic [9:0] a, logic s64, output logic [63:0] d);
        @(negedge clk);
        req = 1; we = 0; addr = a; sz64 = s64;
        @(negedge clk);
        req = 0;
        d = rdata;
        last_rv = rvalid;
    endtask

    task automatic t_reset();
        logic [63:0] v;
        bus_rd(10'h0F0, 1, v); check("R1 counter reset", v, 64'h0);
        check("R12 rvalid after read", 64'(last_rv), 64'h1);
        @(negedge clk);
        check("R12 rvalid idle", 64'(rvalid), 64'h0);
        bus_rd(10'h010, 1, v); check("R1 global control reset", v, 64'h0);
        bus_rd(10'h100, 1, v); check("R1 timer cfg reset", v, TCFG_RST);
        bus_rd(10'h108, 1, v); check("R1 comparator reset", v, '1);
        bus_rd(10'h020, 1, v); check("R1 status reset", v, 64'h0);
    endtask

    task automatic t_cap();
        logic [63:0] v;
        bus_rd(10'h000, 1, v); check("R2 capability", v, {PFS, 32'h0000_A201});
        bus_wr(10'h000, '1, 1);
        bus_rd(10'h000, 1, v); check("R2 capability write ignored", v, {PFS, 32'h0000_A201});
        bus_rd(10'h004, 0, v); check("R3 upper half read", v, {32'h0, PFS});
        bus_rd(10'h000, 0, v); check("R3 lower half read", v, 64'h0000_A201);
    endtask

    task automatic t_gcfg();
        logic [63:0] v;
        bus_wr(10'h010, 64'hFFFF_FFFF_FFFF_FFFC, 1);
        bus_rd(10'h010, 1, v); check("R6 masked bits read zero", v, 64'h0);
        bus_wr(10'h010, 64'h2, 1);
        bus_rd(10'h010, 1, v); check("R6 legacy bit", v, 64'h2);
        check("R6 legacy port", 64'(legacy), 64'h1);
        bus_wr(10'h010, 64'h0, 1);
    endtask

    task automatic t_tcfg();
        logic [63:0] v;
        bus_wr(10'h120, '1, 1);
        bus_rd(10'h120, 1, v); check("R7 cfg all-ones write", v, {RCAP, 32'h0000_3F3E});
        bus_wr(10'h124, 64'h0, 0);
        bus_rd(10'h120, 1, v); check("R7 cfg upper read-only", v, {RCAP, 32'h0000_3F3E});
        bus_wr(10'h120, 64'h0, 0);
        bus_rd(10'h120, 1, v); check("R7 cfg cleared", v, TCFG_RST);
    endtask

    task automatic t_window();
        logic [63:0] v;
        bus_wr(10'h150, 64'h1122_3344_5566_7788, 1);
        bus_rd(10'h150, 1, v); check("R8 timer2 route", v, 64'h1122_3344_5566_7788);
        bus_rd(10'h158, 1, v); check("R8 reserved slot", v, 64'h0);
        bus_wr(10'h148, 64'hAAAA_5555, 0);
        bus_rd(10'h148, 1, v); check("R3 lower half write", v, 64'hFFFF_FFFF_AAAA_5555);
        bus_wr(10'h14C, 64'h1234_5678, 0);
        bus_rd(10'h14C, 0, v); check("R3 upper half write", v, 64'h1234_5678);
    endtask

    task automatic t_oor();
        logic [63:0] v;
        bus_wr(10'h168, 64'h0, 1);
        bus_wr(10'h160, 64'h0, 1);
        bus_rd(10'h168, 1, v); check("R9 out-of-range cmp reads zero", v, 64'h0);
        bus_rd(10'h160, 1, v); check("R9 out-of-range cfg reads zero", v, 64'h0);
        bus_rd(10'h108, 1, v); check("R9 timer0 cmp untouched", v, '1);
        bus_rd(10'h100, 1, v); check("R9 timer0 cfg untouched", v, TCFG_RST);
    endtask

    task automatic t_m32();
        logic [63:0] v;
        bus_wr(10'h108, 64'hDEAD_BEEF_0123_4567, 1);
        bus_rd(10'h108, 1, v); check("R10 64-bit cmp", v, 64'hDEAD_BEEF_0123_4567);
        bus_wr(10'h100, 64'h100, 0);
        bus_rd(10'h108, 1, v); check("R10 mode set truncates", v, 64'h0123_4567);
        bus_wr(10'h10C, 64'hFFFF, 0);
        bus_rd(10'h108, 1, v); check("R10 upper write ignored", v, 64'h0123_4567);
        bus_wr(10'h108, 64'hFFFF_FFFF_89AB_CDEF, 1);
        bus_rd(10'h108, 1, v); check("R10 wide write low only", v, 64'h89AB_CDEF);
    endtask

    task automatic t_status();
        logic [63:0] v;
        @(negedge clk); irq = 3'b010;
        @(negedge clk); irq = '0;
        bus_rd(10'h020, 1, v); check("R11 event sets status", v, 64'h2);
        bus_wr(10'h020, 64'h1, 0);
        bus_rd(10'h020, 1, v); check("R11 clear other bit no effect", v, 64'h2);
        bus_wr(10'h020, 64'h2, 0);
        bus_rd(10'h020, 1, v); check("R11 write one clears", v, 64'h0);
        @(negedge clk);
        req = 1; we = 1; addr = 10'h020; wdata = 64'h4; sz64 = 0; irq = 3'b100;
        @(negedge clk);
        req = 0; we = 0; irq = '0;
        bus_rd(10'h020, 1, v); check("R11 set wins over clear", v, 64'h4);
        bus_wr(10'h020, 64'h4, 0);
    endtask

    task automatic t_count();
        logic [63:0] v, a, b;
        tick = 0;
        bus_wr(10'h0F0, 64'h100, 1);
        check("R5 no warn while halted", 64'(last_warn), 64'h0);
        bus_wr(10'h010, 64'h1, 1);
        @(negedge clk); tick = 1;
        repeat (5) @(negedge clk);
        tick = 0;
        bus_rd(10'h0F0, 1, v); check("R4 five ticks", v, 64'h105);
        tick = 1;
        bus_rd(10'h0F0, 1, a);
        bus_rd(10'h0F0, 1, b);
        check("R4 live read advances", 64'(b > a), 64'h1);
        bus_wr(10'h010, 64'h0, 1);
        bus_rd(10'h0F0, 1, a);
        repeat (5) @(negedge clk);
        bus_rd(10'h0F0, 1, b);
        check("R4 frozen while halted", b, a);
        tick = 0;
    endtask

    task automatic t_cnt_write();
        logic [63:0] v;
        tick = 1;
        bus_wr(10'h010, 64'h1, 1);
        bus_wr(10'h0F0, 64'h50, 1);
        check("R5 warn on running write", 64'(last_warn), 64'h1);
        bus_wr(10'h010, 64'h0, 1);
        bus_rd(10'h0F0, 1, v); check("R5 write wins over tick", v, 64'h52);
        tick = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not complete");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_cap();
        t_gcfg();
        t_tcfg();
        t_window();
        t_oor();
        t_m32();
        t_status();
        t_count();
        t_cnt_write();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule